// File: doc/BRIEF.md
# Guarded Downward Data-Stack Pointer

This block holds the pointer for a software data stack that lives in a 12-bit, nibble-addressed data space. It turns single-cycle push and pop strobes into a memory address together with a write or read enable. The memory array is outside the block. After reset the pointer sits at the highest stack location, 0x3FF. Pushes move it toward lower addresses.

A guard address, 0x300, marks the floor of the stack. A push that would carry the pointer below the floor is refused in the same cycle, so no write reaches memory. A pop increments the pointer modulo 2^12. Repeated pops therefore climb to 0xFFF and then wrap to 0x000. That address lies below the same floor, so no separate ceiling compare is needed and the wrapping pop faults as well.

Any refused command, including a push and a pop strobed together, sets a sticky fault. The fault freezes the pointer and blocks all memory traffic until the next reset.

Top module: `stack_guard_ptr`

## Requirements
- R1: After a synchronous active-low reset, with no strobe, `mem_addr_o` is 0x3FF, `mem_we_o` and `mem_re_o` are 0 and `fault_o` is 0.
- R2: A lone push with pointer P > 0x300 and no fault drives `mem_we_o`=1, `mem_addr_o`=P and `mem_wdata_o`=`push_data_i` in the same cycle. The pointer then becomes P-1.
- R3: A lone pop with pointer P, no fault and (P+1) mod 4096 ≥ 0x300 drives `mem_re_o`=1 and `mem_addr_o`=(P+1) mod 4096 in the same cycle. The pointer then becomes that value.
- R4: A lone push with pointer P = 0x300 drives `mem_we_o`=0 in that cycle and leaves the pointer at 0x300. `fault_o` is 1 from the next cycle.
- R5: A lone pop with pointer 0xFFF drives `mem_addr_o`=0x000 and `mem_re_o`=0. The pointer stays at 0xFFF, and `fault_o` is 1 from the next cycle.
- R6: Pops that take the pointer above 0x3FF, up to and including 0xFFF, are legal and raise no fault.
- R7: A push and a pop in the same cycle drive neither enable and leave the pointer unchanged. `fault_o` is 1 from the next cycle.
- R8: Once `fault_o` is 1 it stays 1 until reset. While it is 1, `mem_we_o` and `mem_re_o` stay 0 and the pointer does not move.
- R9: With no strobe, `mem_addr_o` shows the current pointer, both enables are 0 and the pointer holds. For every command other than a lone pop, `mem_addr_o` equals the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push strobe, one item per cycle |
| pop_i | input | 1 | Pop strobe, one item per cycle |
| push_data_i | input | 4 | Nibble to store on a push |
| mem_addr_o | output | 12 | Data-space address for the current command |
| mem_we_o | output | 1 | Write enable toward the memory |
| mem_wdata_o | output | 4 | Write data toward the memory |
| mem_re_o | output | 1 | Read enable toward the memory |
| fault_o | output | 1 | Sticky stack fault |

## Verification
Random mixes of idle cycles, pushes and pops, with a rare simultaneous strobe, walk the pointer around inside the stack region. These runs separate correct address offsets (write at the pointer, read one above it) from swapped or misaligned ones. A directed fill of 255 pushes followed by one more tells an exact floor compare apart from one that is off by a single location. A run of 3072 pops followed by one more shows that climbing above the region is tolerated and that only the wrap to zero faults. Strobes applied after a fault, followed by a reset, show that the fault is sticky, that it freezes the pointer, and that reset clears it.

// File: rtl/sgp_pkg.sv
// Shared types for the guarded stack pointer.
// Assumes: one command per cycle, decoded from two strobes.
package sgp_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_POP  = 2'd2,
        CMD_BOTH = 2'd3
    } sp_cmd_e;
endpackage

// File: rtl/sgp_cmd_decode.sv
// Folds the push and pop strobes into one command code.
// Assumes: strobes are synchronous to the pointer clock.
module sgp_cmd_decode
    import sgp_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    output sp_cmd_e cmd_o
);
    // Map the strobe pair onto the command enum.
    always_comb begin
        unique case ({pop_i, push_i})
            2'b01:   cmd_o = CMD_PUSH;
            2'b10:   cmd_o = CMD_POP;
            2'b11:   cmd_o = CMD_BOTH;
            default: cmd_o = CMD_IDLE;
        endcase
    end
endmodule

// File: rtl/sgp_next_ptr.sv
// Computes the access address, the candidate next pointer and whether
// the command breaks the guard floor.
// Assumes: a pop wraps modulo 2**ADDR_W, and a push never wraps because
// the floor lies above zero.
module sgp_next_ptr
    import sgp_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]    GUARD_ADDR = 12'h300
) (
    input  logic [ADDR_W-1:0] sp_i,
    input  sp_cmd_e           cmd_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] sp_next_o,
    output logic              violation_o,
    output logic              push_ok_o,
    output logic              pop_ok_o
);
    logic [ADDR_W-1:0] sp_up;
    logic [ADDR_W-1:0] sp_down;

    // Neighbouring pointer values; the increment wraps to zero by design.
    always_comb begin
        sp_up   = sp_i + ADDR_W'(1);
        sp_down = sp_i - ADDR_W'(1);
    end

    // Per-command address, legality and next pointer.
    always_comb begin
        addr_o      = sp_i;
        sp_next_o   = sp_i;
        violation_o = 1'b0;
        push_ok_o   = 1'b0;
        pop_ok_o    = 1'b0;
        unique case (cmd_i)
            CMD_PUSH: begin
                if (sp_i > GUARD_ADDR) begin
                    push_ok_o = 1'b1;
                    sp_next_o = sp_down;
                end else begin
                    violation_o = 1'b1;
                end
            end
            CMD_POP: begin
                addr_o = sp_up;
                if (sp_up >= GUARD_ADDR) begin
                    pop_ok_o  = 1'b1;
                    sp_next_o = sp_up;
                end else begin
                    violation_o = 1'b1;
                end
            end
            CMD_BOTH: violation_o = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/sgp_fault_latch.sv
// Sticky fault flag: set by any violation, cleared only by reset.
// Assumes: synchronous active-low reset.
module sgp_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic fault_o
);
    // Hold the flag once it has been set.
    always_ff @(posedge clk) begin
        if (!rst_n)     fault_o <= 1'b0;
        else if (set_i) fault_o <= 1'b1;
    end
endmodule

// File: rtl/stack_guard_ptr.sv
// Downward-growing data-stack pointer with a guard floor and a sticky fault.
// A push writes at the pointer and then decrements it. A pop increments
// the pointer and then reads there. A fault freezes the pointer and
// blocks all memory access.
// Assumes: the memory sits outside this block and accepts a command in
// the cycle it is presented.
module stack_guard_ptr
    import sgp_pkg::*;
#(
    parameter int unsigned          ADDR_W     = 12,
    parameter int unsigned          DATA_W     = 4,
    parameter logic [ADDR_W-1:0]    TOP_ADDR   = 12'h3FF,
    parameter logic [ADDR_W-1:0]    GUARD_ADDR = 12'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_re_o,
    output logic              fault_o
);
    sp_cmd_e           cmd;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] sp_next;
    logic              violation;
    logic              push_ok;
    logic              pop_ok;

    sgp_cmd_decode u_decode (
        .push_i (push_i),
        .pop_i  (pop_i),
        .cmd_o  (cmd)
    );

    sgp_next_ptr #(
        .ADDR_W     (ADDR_W),
        .GUARD_ADDR (GUARD_ADDR)
    ) u_next (
        .sp_i        (sp_q),
        .cmd_i       (cmd),
        .addr_o      (mem_addr_o),
        .sp_next_o   (sp_next),
        .violation_o (violation),
        .push_ok_o   (push_ok),
        .pop_ok_o    (pop_ok)
    );

    sgp_fault_latch u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (violation && !fault_o),
        .fault_o (fault_o)
    );

    // Pointer register: reset to the top, frozen while faulted.
    always_ff @(posedge clk) begin
        if (!rst_n)        sp_q <= TOP_ADDR;
        else if (!fault_o) sp_q <= sp_next;
    end

    // Memory strobes, gated by the sticky fault.
    always_comb begin
        mem_we_o    = push_ok && !fault_o;
        mem_re_o    = pop_ok && !fault_o;
        mem_wdata_o = push_data_i;
    end
endmodule

// File: rtl/stack_guard_ptr_chk.sv
// Port-level properties of the guarded stack pointer, bound to the top.
// Assumes: synchronous active-low reset; properties are disabled during it.
module stack_guard_ptr_chk #(
    parameter int unsigned          ADDR_W     = 12,
    parameter logic [ADDR_W-1:0]    GUARD_ADDR = 12'h300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              fault_o
);
    // R4: writes never land on or below the floor.
    a_r4_write_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o > GUARD_ADDR));

    // R5: reads never target an address below the floor.
    a_r5_read_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |-> (mem_addr_o >= GUARD_ADDR));

    // R7: a simultaneous strobe pair moves no data.
    a_r7_both_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |-> (!mem_we_o && !mem_re_o));

    // R7: a simultaneous strobe pair raises the fault.
    a_r7_both_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> fault_o);

    // R8: the fault never clears without reset.
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R8: no memory access while faulted.
    a_r8_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!mem_we_o && !mem_re_o));

    // R2/R3: at most one enable at a time.
    a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_re_o}));
endmodule

bind stack_guard_ptr stack_guard_ptr_chk #(
    .ADDR_W     (ADDR_W),
    .GUARD_ADDR (GUARD_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .mem_addr_o (mem_addr_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .fault_o    (fault_o)
);

// File: tb/test_stack_guard_ptr.sv
`timescale 1ns/1ps
// Self-checking bench: random push/pop mixes plus directed floor, wrap,
// collision and sticky-fault cases, checked against a bench-side model.
module test_stack_guard_ptr;
    localparam int unsigned AW    = 12;
    localparam int unsigned DW    = 4;
    localparam logic [AW-1:0] TOP = 12'h3FF;
    localparam logic [AW-1:0] GRD = 12'h300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [DW-1:0] push_data_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_we_o;
    logic [DW-1:0] mem_wdata_o;
    logic          mem_re_o;
    logic          fault_o;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] m_sp = TOP;
    logic          m_fault = 1'b0;

    always #2.5 clk = ~clk;

    stack_guard_ptr i_stack_guard_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .mem_addr_o  (mem_addr_o),
        .mem_we_o    (mem_we_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_re_o    (mem_re_o),
        .fault_o     (fault_o)
    );

    function automatic logic [AW-1:0] exp_addr(logic pu, logic po);
        return (po && !pu) ? AW'(m_sp + 1) : m_sp;
    endfunction

    function automatic logic exp_we(logic pu, logic po);
        return !m_fault && pu && !po && (m_sp > GRD);
    endfunction

    function automatic logic exp_re(logic pu, logic po);
        logic [AW-1:0] up = AW'(m_sp + 1);
        return !m_fault && po && !pu && (up >= GRD);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Apply one command for one cycle, check outputs mid-cycle, advance model.
    task automatic step(logic pu, logic po, logic [DW-1:0] d, string tag);
        logic          bad;
        logic [AW-1:0] up;
        @(negedge clk);
        push_i = pu; pop_i = po; push_data_i = d;
        #1;
        chk(tag, "addr",  int'(mem_addr_o), int'(exp_addr(pu, po)));
        chk(tag, "we",    int'(mem_we_o),   int'(exp_we(pu, po)));
        chk(tag, "re",    int'(mem_re_o),   int'(exp_re(pu, po)));
        chk(tag, "fault", int'(fault_o),    int'(m_fault));
        if (exp_we(pu, po)) chk(tag, "wdata", int'(mem_wdata_o), int'(d));
        @(posedge clk);
        up  = AW'(m_sp + 1);
        bad = (pu && po) || (pu && !po && m_sp <= GRD) || (po && !pu && up < GRD);
        if (!m_fault) begin
            if (bad)            m_fault = 1'b1;
            else if (pu && !po) m_sp = AW'(m_sp - 1);
            else if (po && !pu) m_sp = up;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_sp = TOP; m_fault = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        do_reset();
        step(1'b0, 1'b0, 4'h0, "R1");               // R1 reset state
        step(1'b0, 1'b0, 4'h0, "R9");               // R9 idle holds

        // Random mixes; reset after a fault has been observed sticky.
        for (int i = 0; i < 2000; i++) begin
            int r = int'($urandom_range(0, 99));
            logic pu = (r < 55);
            logic po = (r >= 50 && r < 90);
            if (!pu && !po) step(1'b0, 1'b0, 4'h0, "R9");
            else if (pu && po) step(1'b1, 1'b1, 4'h0, "R7");
            else if (pu) step(1'b1, 1'b0, 4'($urandom), "R2");
            else step(1'b0, 1'b1, 4'h0, "R3");
            if (m_fault) begin
                step(1'b1, 1'b0, 4'h5, "R8");
                step(1'b0, 1'b1, 4'h0, "R8");
                do_reset();
            end
        end

        // R4: fill to the floor, then one push too many.
        do_reset();
        for (int i = 0; i < 255; i++) step(1'b1, 1'b0, 4'(i), "R2");
        step(1'b1, 1'b0, 4'hA, "R4");
        step(1'b0, 1'b0, 4'h0, "R4");
        step(1'b0, 1'b1, 4'h0, "R8");               // R8 frozen and sticky
        step(1'b1, 1'b0, 4'h3, "R8");

        // R6 climb above region, then R5 wrap to zero.
        do_reset();
        for (int i = 0; i < 3072; i++) step(1'b0, 1'b1, 4'h0, "R6");
        step(1'b0, 1'b0, 4'h0, "R6");
        step(1'b0, 1'b1, 4'h0, "R5");
        step(1'b0, 1'b0, 4'h0, "R5");

        // R7 collision from a clean state.
        do_reset();
        step(1'b1, 1'b0, 4'h9, "R2");
        step(1'b1, 1'b1, 4'h1, "R7");
        step(1'b0, 1'b0, 4'h0, "R7");
        do_reset();
        step(1'b0, 1'b0, 4'h0, "R1");               // R1 reset clears fault

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule